// File: doc/BRIEF.md
# Memory Write Packet Decoder

The block takes a stream of 32-bit words over a valid/ready handshake and looks for write packets in it. A packet starts with a marker word of all ones. The next word is a byte count, the word after that is a target memory address, and the payload words follow with no gap. The decoder sends each payload word out as one write on a simple memory write port. The first write goes to the header address, and each later write goes to the next word address.

While the decoder is searching, it discards anything that is not the marker word. A byte count that is zero, or that is not a whole number of words, aborts the packet: the decoder raises a one-cycle error flag and goes back to searching. During the payload, the memory port's ready signal controls the stream, so a stalled memory holds both the input and the write. A one-cycle done flag follows the last write of each packet.

States: `ST_HUNT` searches for the marker. `ST_SIZE` takes the byte count. `ST_ADDR` takes the address. `ST_BODY` forwards the payload. The transitions are:
- HUNT to SIZE on an accepted marker word.
- SIZE to ADDR on an accepted valid count.
- SIZE to HUNT on an accepted bad count.
- ADDR to BODY on an accepted address.
- BODY to HUNT on the last payload write.

Every other case holds the state.

Top module: `pkt_mem_writer`

## Requirements
- R1: After reset the decoder is searching, with `in_ready`=1, `wr_en`=0, `pkt_done`=0 and `pkt_err`=0.
- R2: While searching, every accepted word other than 0xFFFFFFFF is dropped, and no write or flag results from it.
- R3: After the marker, the next accepted word is the byte count and the one after it is the address. The first payload word is written to that address, with its two low bits forced to zero.
- R4: Each later payload write goes to the previous write address plus 4.
- R5: A packet with byte count N makes exactly N/4 writes. Words that follow it are searched again for a marker, and a 0xFFFFFFFF word inside the payload is treated as data.
- R6: A byte count of zero raises `pkt_err` for exactly the one cycle after the count is accepted. No write follows, and the decoder goes back to searching.
- R7: A byte count whose two low bits are not 00 is handled the same way as in R6.
- R8: During the payload, `in_ready` equals `wr_ready`. A write takes place only in a cycle where `wr_en` and `wr_ready` are both 1, and while `wr_ready` is 0 the write address holds.
- R9: `pkt_done` is high for exactly the one cycle after the last payload write of a packet.
- R10: `wr_data` equals the payload word accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | WORD_W | Stream word |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Decoder takes the word this cycle |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | WORD_W | Write data |
| wr_en | output | 1 | Write request |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| pkt_done | output | 1 | One-cycle pulse after the last write of a packet |
| pkt_err | output | 1 | One-cycle pulse after a rejected byte count |

## Verification
The write port and `in_ready` are combinational from the current state and inputs, so a write is due in the same cycle that its payload word is accepted. The bench samples them 2 ns after it drives the inputs at the falling edge. The two flags are registered, so each is due in the cycle after the handshake that causes it. The bench records that handshake and compares the flags at the sample point of the following cycle. Random gaps on `in_valid` and random stalls on `wr_ready` move these due cycles around, so every expectation is tied to an observed handshake and never to a fixed cycle count.

// File: rtl/pkt_mem_writer_pkg.sv
package pkt_mem_writer_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SIZE = 2'd1,
        ST_ADDR = 2'd2,
        ST_BODY = 2'd3
    } pw_state_e;

endpackage

// File: rtl/pkt_mem_writer_track.sv
module pkt_mem_writer_track #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_size,
    input  logic              load_addr,
    input  logic              beat,
    input  logic [WORD_W-1:0] word,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_beat
);
    localparam int CNT_W = WORD_W - 2;

    logic [CNT_W-1:0] words_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left <= '0;
            cur_addr   <= '0;
        end else begin
            if (load_size)
                words_left <= word[WORD_W-1:2];
            else if (beat)
                words_left <= words_left - CNT_W'(1);
            if (load_addr)
                cur_addr <= {word[ADDR_W-1:2], 2'b00};
            else if (beat)
                cur_addr <= cur_addr + ADDR_W'(4);
        end
    end

    assign last_beat = (words_left == CNT_W'(1));

endmodule

// File: rtl/pkt_mem_writer_fsm.sv
module pkt_mem_writer_fsm
    import pkt_mem_writer_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              wr_ready,
    input  logic              last_beat,
    output logic              in_ready,
    output logic              wr_en,
    output logic              load_size,
    output logic              load_addr,
    output logic              beat,
    output logic              pkt_done,
    output logic              pkt_err
);
    localparam logic [WORD_W-1:0] MARKER = '1;

    pw_state_e state, nxt;
    logic      bad_size;
    logic      done_set, err_set;

    assign bad_size = (in_data == '0) || (in_data[1:0] != 2'b00);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: if (in_valid && in_data == MARKER) nxt = ST_SIZE;
            ST_SIZE: if (in_valid) nxt = bad_size ? ST_HUNT : ST_ADDR;
            ST_ADDR: if (in_valid) nxt = ST_BODY;
            ST_BODY: if (in_valid && wr_ready && last_beat) nxt = ST_HUNT;
            default: nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            pkt_done <= 1'b0;
            pkt_err  <= 1'b0;
        end else begin
            state    <= nxt;
            pkt_done <= done_set;
            pkt_err  <= err_set;
        end
    end

    always_comb begin
        in_ready  = 1'b1;
        wr_en     = 1'b0;
        load_size = 1'b0;
        load_addr = 1'b0;
        beat      = 1'b0;
        done_set  = 1'b0;
        err_set   = 1'b0;
        unique case (state)
            ST_HUNT: ;
            ST_SIZE: begin
                load_size = in_valid && !bad_size;
                err_set   = in_valid && bad_size;
            end
            ST_ADDR: load_addr = in_valid;
            ST_BODY: begin
                in_ready = wr_ready;
                wr_en    = in_valid;
                beat     = in_valid && wr_ready;
                done_set = in_valid && wr_ready && last_beat;
            end
            default: ;
        endcase
    end

    assert_err_back_to_hunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> (state == ST_HUNT));

    assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    assert_done_in_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (state == ST_HUNT) && !wr_en);

endmodule

// File: rtl/pkt_mem_writer.sv
module pkt_mem_writer #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_en,
    input  logic              wr_ready,
    output logic              pkt_done,
    output logic              pkt_err
);
    logic load_size, load_addr, beat, last_beat;

    pkt_mem_writer_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .wr_ready  (wr_ready),
        .last_beat (last_beat),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .load_size (load_size),
        .load_addr (load_addr),
        .beat      (beat),
        .pkt_done  (pkt_done),
        .pkt_err   (pkt_err)
    );

    pkt_mem_writer_track #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_size (load_size),
        .load_addr (load_addr),
        .beat      (beat),
        .word      (in_data),
        .cur_addr  (wr_addr),
        .last_beat (last_beat)
    );

    assign wr_data = in_data;

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && !last_beat) |=> (wr_addr == $past(wr_addr) + ADDR_W'(4)));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(wr_addr));

endmodule

// File: tb/pkt_mem_writer_tb_top.sv
module pkt_mem_writer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_en;
    logic        wr_ready = 1'b1;
    logic        pkt_done;
    logic        pkt_err;

    always #5 clk = ~clk;

    pkt_mem_writer dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .wr_ready(wr_ready), .pkt_done(pkt_done), .pkt_err(pkt_err)
    );

    // tags: 0 header/junk, 1 last payload, 2 rejected count, 3 payload
    logic [31:0] in_q[$];
    int          tag_q[$];
    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    int n_checks = 0;
    int n_errors = 0;
    int exp_writes = 0;
    int seen_writes = 0;
    int exp_dones = 0;
    int seen_dones = 0;
    int exp_errs = 0;
    int seen_errs = 0;

    function automatic bit fn_bad_count(input logic [31:0] bytes);
        return (bytes == 32'd0) || (bytes[1:0] != 2'b00);
    endfunction

    function automatic logic [31:0] fn_word_addr(input logic [31:0] base, input int idx);
        return {base[31:2], 2'b00} + 32'(idx * 4);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w, input int tag);
        in_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic add_junk(input int n);
        for (int i = 0; i < n; i++) push_word($urandom & 32'h7FFF_FFFF, 0);
    endtask

    task automatic add_pkt(input logic [31:0] base, input logic [31:0] bytes, input bit all_ones_payload);
        push_word(32'hFFFF_FFFF, 0);
        if (fn_bad_count(bytes)) begin
            push_word(bytes, 2);
            exp_errs++;
            return;
        end
        push_word(bytes, 0);
        push_word(base, 0);
        for (int i = 0; i < int'(bytes >> 2); i++) begin
            logic [31:0] d;
            d = all_ones_payload ? 32'hFFFF_FFFF : $urandom;
            push_word(d, (i == int'(bytes >> 2) - 1) ? 1 : 3);
            exp_addr_q.push_back(fn_word_addr(base, i));
            exp_data_q.push_back(d);
            exp_writes++;
        end
        exp_dones++;
    endtask

    initial begin
        int seed_val;
        int cyc;
        int drain;
        bit exp_done_now;
        bit exp_err_now;
        seed_val = $urandom(32'd20511);

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
        chk(wr_en == 1'b0, "R1", "wr_en after reset", 32'(wr_en), 32'd0);
        chk(pkt_done == 1'b0 && pkt_err == 1'b0, "R1", "flags after reset",
            {30'd0, pkt_done, pkt_err}, 32'd0);

        // directed cases
        add_junk(3);                                    // R2
        add_pkt(32'h0000_1000, 32'd16, 1'b0);           // R3 R4 R5
        add_pkt(32'h0000_2000, 32'd0, 1'b0);            // R6 zero count
        add_junk(2);
        add_pkt(32'h0000_3000, 32'd6, 1'b0);            // R7 odd count
        add_pkt(32'h0000_0022, 32'd4, 1'b0);            // R3 low bits forced, single word
        add_pkt(32'h0000_4000, 32'd12, 1'b1);           // R5 marker inside payload
        add_pkt(32'h0000_5000, 32'd8, 1'b0);            // back to back
        add_junk(1);
        // constrained random packets
        for (int p = 0; p < 30; p++) begin
            int nw;
            logic [31:0] bytes;
            if ($urandom % 4 == 0) add_junk(1 + $urandom % 3);
            nw = 1 + ($urandom % 8);
            bytes = 32'(nw * 4);
            if ($urandom % 6 == 0) bytes = bytes + 32'(1 + $urandom % 3);
            add_pkt({$urandom & 32'h00FF_FFFF}, bytes, 1'b0);
        end

        cyc = 0;
        drain = 0;
        exp_done_now = 1'b0;
        exp_err_now = 1'b0;
        while ((in_q.size() > 0 || drain < 4) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            wr_ready = ($urandom % 4) != 0;
            if (in_q.size() > 0 && ($urandom % 5) != 0) begin
                in_valid = 1'b1;
                in_data  = in_q[0];
            end else begin
                in_valid = 1'b0;
                in_data  = $urandom;
            end
            #2;
            // registered flags from last cycle's handshake
            if (pkt_done || exp_done_now)
                chk(pkt_done == exp_done_now, "R9", "pkt_done pulse", 32'(pkt_done), 32'(exp_done_now));
            if (pkt_err || exp_err_now)
                chk(pkt_err == exp_err_now, "R6/R7", "pkt_err pulse", 32'(pkt_err), 32'(exp_err_now));
            if (pkt_done) seen_dones++;
            if (pkt_err) seen_errs++;
            exp_done_now = 1'b0;
            exp_err_now = 1'b0;

            if (wr_en && !wr_ready)
                chk(in_ready == 1'b0, "R8", "in_ready during stall", 32'(in_ready), 32'd0);
            if (wr_en && wr_ready) begin
                seen_writes++;
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected write", wr_addr, 32'd0);
                end else begin
                    logic [31:0] ea, ed;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    chk(wr_addr == ea, "R3/R4", "write address", wr_addr, ea);
                    chk(wr_data == ed, "R10", "write data", wr_data, ed);
                end
            end
            if (in_valid && in_ready) begin
                int t;
                t = tag_q.pop_front();
                void'(in_q.pop_front());
                if (t == 1 || t == 3)
                    chk(wr_en && wr_ready, "R8", "payload word written", 32'(wr_en && wr_ready), 32'd1);
                if (t == 1) exp_done_now = 1'b1;
                if (t == 2) exp_err_now = 1'b1;
            end
            if (in_q.size() == 0) drain++;
        end

        if (cyc >= 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: stream not drained, actual=%0d expected=0 words left", in_q.size());
        end
        chk(seen_writes == exp_writes, "R5", "total writes", 32'(seen_writes), 32'(exp_writes));
        chk(seen_dones == exp_dones, "R9", "total done pulses", 32'(seen_dones), 32'(exp_dones));
        chk(seen_errs == exp_errs, "R6/R7", "total error pulses", 32'(seen_errs), 32'(exp_errs));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule